// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves words between them in either direction. Each direction has a storage register and a per-bit two-way selector. The selector forwards either the live word arriving from the far bus or a word captured earlier. Tri-state pins are split into separate input, output and output-enable ports. The surrounding pad logic joins them into real bidirectional pins, so the input port of a side reflects whatever that side is driving.

Captures run on one system clock with a capture-enable per register, in the usual FPGA manner. A strobe loads its register on every clock edge where it is high, whatever the selects and enables say. The selectors are plain combinational logic, so a driven word changes only when its chosen source or its select changes.

Output-enable decoding has two build-time variants. In the direction variant, one active-low enable isolates both sides and a direction input picks which side is driven. In the split variant, a B-side enable and an active-low A-side enable are independent, so both buses can be driven at once. A further parameter inverts every driven bit. It is off by default.

Top module: `txr_bus_xcvr`

## Requirements
- R1: A high `rst` at a clock edge clears both stored words to zero. The stored words are observed through the outputs with both selects at 1.
- R2: At a clock edge with `cap_a` high, the A-side stored word takes `a_in`. It does so whatever the selects and control inputs are. With `cap_a` low, the word is held.
- R3: At a clock edge with `cap_b` high, the B-side stored word takes `b_in`. It does so whatever the selects and control inputs are. With `cap_b` low, the word is held.
- R4: `b_out` equals `a_in` in the same cycle when `sel_a2b` is 0. It equals the A-side stored word when `sel_a2b` is 1.
- R5: `a_out` equals `b_in` in the same cycle when `sel_b2a` is 0. It equals the B-side stored word when `sel_b2a` is 1.
- R6: In the direction variant (`OE_MODE` = `OE_DIR_EN`), `ctrl0` is an active-low enable: `ctrl0` = 1 deasserts both `a_oe` and `b_oe`. With `ctrl0` = 0, `ctrl1` = 1 asserts only `b_oe` and `ctrl1` = 0 asserts only `a_oe`.
- R7: In the split variant (`OE_MODE` = `OE_SPLIT`), `b_oe` equals `ctrl0` and `a_oe` equals the inverse of `ctrl1`. So `ctrl0` = 1 with `ctrl1` = 0 drives both buses at once, each with its selected word.
- R8: While the B side is driven with live A data and `b_in` carries that driven word, one edge with both `cap_a` and `cap_b` high stores the same input word in both registers.
- R9: A side whose output-enable is low still presents its selected word on its output port.
- R10: When a select, its live source and its stored word are all unchanged since the previous clock edge, the output of that direction is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all captures happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both stored words |
| a_in | input | W | Word seen on the A-side pins |
| b_in | input | W | Word seen on the B-side pins |
| cap_a | input | 1 | Capture strobe for the A-side register |
| cap_b | input | 1 | Capture strobe for the B-side register |
| sel_a2b | input | 1 | 0: live A data to B; 1: stored A word to B |
| sel_b2a | input | 1 | 0: live B data to A; 1: stored B word to A |
| ctrl0 | input | 1 | Direction variant: active-low enable; split variant: B-side enable |
| ctrl1 | input | 1 | Direction variant: direction (1 = drive B); split variant: active-low A-side enable |
| a_out | output | W | Word to drive onto the A-side pins |
| a_oe | output | 1 | Output-enable for the A-side pins |
| b_out | output | W | Word to drive onto the B-side pins |
| b_oe | output | 1 | Output-enable for the B-side pins |

## Verification
A corrupted stored word stays hidden until a select of 1 routes it out. The bench therefore reads each register through its select one clock after every capture and every reset. A wrong enable decode appears on `a_oe` and `b_oe` in the same cycle as the control change, so every control pattern is checked in both variants at once. A selector that picks the wrong source shows up at once as a live word where a stored one was expected, or the reverse. The vectors therefore keep the live and stored words distinct.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Output-enable decoding variant
  typedef enum logic [0:0] {
    OE_DIR_EN = 1'b0,  // active-low enable plus direction
    OE_SPLIT  = 1'b1   // independent enable per driven side
  } oe_mode_e;
endpackage

// File: rtl/txr_store_reg.sv
module txr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/txr_src_mux.sv
module txr_src_mux #(
  parameter int W   = 8,
  parameter bit INV = 1'b0
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  // One independent 2:1 selector per bit; no shared decode, so a
  // bit only moves when its chosen input or the select moves.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (INV) begin : g_inv
      assign y[i] = ~(sel ? stored[i] : live[i]);
    end else begin : g_pass
      assign y[i] = sel ? stored[i] : live[i];
    end
  end
endmodule

// File: rtl/txr_oe_decode.sv
module txr_oe_decode #(
  parameter txr_pkg::oe_mode_e MODE = txr_pkg::OE_DIR_EN
) (
  input  logic ctrl0,
  input  logic ctrl1,
  output logic a_oe,
  output logic b_oe
);
  if (MODE == txr_pkg::OE_DIR_EN) begin : g_dir
    // ctrl0 active-low enable, ctrl1 picks the driven side
    assign b_oe = ~ctrl0 &  ctrl1;
    assign a_oe = ~ctrl0 & ~ctrl1;
  end else begin : g_split
    // ctrl0 enables B side (high), ctrl1 enables A side (low)
    assign b_oe = ctrl0;
    assign a_oe = ~ctrl1;
  end
endmodule

// File: rtl/txr_bus_xcvr.sv
module txr_bus_xcvr #(
  parameter int                W       = 8,
  parameter txr_pkg::oe_mode_e OE_MODE = txr_pkg::OE_DIR_EN,
  parameter bit                INV_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic         ctrl0,
  input  logic         ctrl1,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] st_a;
  logic [W-1:0] st_b;

  txr_store_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst(rst), .load(cap_a), .d(a_in), .q(st_a)
  );

  txr_store_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst(rst), .load(cap_b), .d(b_in), .q(st_b)
  );

  txr_src_mux #(.W(W), .INV(INV_OUT)) u_mux_a2b (
    .sel(sel_a2b), .live(a_in), .stored(st_a), .y(b_out)
  );

  txr_src_mux #(.W(W), .INV(INV_OUT)) u_mux_b2a (
    .sel(sel_b2a), .live(b_in), .stored(st_b), .y(a_out)
  );

  txr_oe_decode #(.MODE(OE_MODE)) u_oe (
    .ctrl0(ctrl0), .ctrl1(ctrl1), .a_oe(a_oe), .b_oe(b_oe)
  );

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (st_a == '0 && st_b == '0));

  p_cap_a_r2: assert property (@(posedge clk) disable iff (rst)
    cap_a |=> (st_a == $past(a_in)));

  p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
    !cap_a |=> $stable(st_a));

  p_cap_b_r3: assert property (@(posedge clk) disable iff (rst)
    cap_b |=> (st_b == $past(b_in)));

  p_hold_b_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_b |=> $stable(st_b));

  p_no_glitch_b_r10: assert property (@(posedge clk) disable iff (rst)
    ($stable(sel_a2b) && $stable(a_in) && $stable(st_a)) |-> $stable(b_out));

  p_no_glitch_a_r10: assert property (@(posedge clk) disable iff (rst)
    ($stable(sel_b2a) && $stable(b_in) && $stable(st_b)) |-> $stable(a_out));

  if (OE_MODE == txr_pkg::OE_DIR_EN) begin : g_chk_dir
    p_isolate_r6: assert property (@(posedge clk) disable iff (rst)
      ctrl0 |-> (!a_oe && !b_oe));
    p_one_side_r6: assert property (@(posedge clk) disable iff (rst)
      !(a_oe && b_oe));
    p_enabled_r6: assert property (@(posedge clk) disable iff (rst)
      !ctrl0 |-> $onehot0({a_oe, b_oe}) && (a_oe || b_oe));
  end else begin : g_chk_split
    p_both_on_r7: assert property (@(posedge clk) disable iff (rst)
      (ctrl0 && !ctrl1) |-> (a_oe && b_oe));
    p_both_off_r7: assert property (@(posedge clk) disable iff (rst)
      (!ctrl0 && ctrl1) |-> (!a_oe && !b_oe));
  end
endmodule

// File: tb/txr_bus_xcvr_bench.sv
module txr_bus_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in;
  logic cap_a, cap_b, sel_a2b, sel_b2a, ctrl0, ctrl1;
  logic [W-1:0] a_out_d, b_out_d, a_out_s, b_out_s;
  logic a_oe_d, b_oe_d, a_oe_s, b_oe_s;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txr_bus_xcvr #(.W(W), .OE_MODE(txr_pkg::OE_DIR_EN)) u_txr_bus_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cap_a(cap_a), .cap_b(cap_b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .ctrl0(ctrl0), .ctrl1(ctrl1),
    .a_out(a_out_d), .a_oe(a_oe_d), .b_out(b_out_d), .b_oe(b_oe_d)
  );

  txr_bus_xcvr #(.W(W), .OE_MODE(txr_pkg::OE_SPLIT)) u_txr_bus_xcvr_split (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cap_a(cap_a), .cap_b(cap_b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .ctrl0(ctrl0), .ctrl1(ctrl1),
    .a_out(a_out_s), .a_oe(a_oe_s), .b_out(b_out_s), .b_oe(b_oe_s)
  );

  // {sab,sba,c0,c1, a_in, b_in, dir a_oe,b_oe, split a_oe,b_oe, a_out, b_out}
  // stored words are 3C (A side) and A5 (B side) while the table runs
  localparam logic [39:0] VEC [NVEC] = '{
    {4'b0011, 8'h11, 8'h22, 4'b0001, 8'h22, 8'h11},
    {4'b1001, 8'h11, 8'h22, 4'b0100, 8'h22, 8'h3C},
    {4'b0100, 8'h5A, 8'h66, 4'b1010, 8'hA5, 8'h5A},
    {4'b1110, 8'h00, 8'hFF, 4'b0011, 8'hA5, 8'h3C},
    {4'b0000, 8'hFF, 8'h00, 4'b1010, 8'h00, 8'hFF},
    {4'b1101, 8'hC3, 8'h7E, 4'b0100, 8'hA5, 8'h3C},
    {4'b0111, 8'h81, 8'h18, 4'b0001, 8'hA5, 8'h81},
    {4'b1010, 8'h42, 8'h24, 4'b0011, 8'h24, 8'h3C}
  };

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; cap_a = 0; cap_b = 0;
    sel_a2b = 0; sel_b2a = 0; ctrl0 = 1; ctrl1 = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0; sel_a2b = 1; sel_b2a = 1;
    #1;
    chk("R1 reset B-out dir", b_out_d, 8'h00);
    chk("R1 reset A-out dir", a_out_d, 8'h00);
    chk("R1 reset B-out split", b_out_s, 8'h00);
    chk("R1 reset A-out split", a_out_s, 8'h00);

    // preload both registers
    @(negedge clk) a_in = 8'h3C; b_in = 8'hA5; cap_a = 1; cap_b = 1;
    @(negedge clk) cap_a = 0; cap_b = 0; a_in = 8'h00; b_in = 8'h00;
    #1;
    chk("R2 preload A store", b_out_d, 8'h3C);
    chk("R3 preload B store", a_out_d, 8'hA5);

    // table walk: select paths and enable decode in both variants
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      {sel_a2b, sel_b2a, ctrl0, ctrl1} = VEC[k][39:36];
      a_in = VEC[k][35:28];
      b_in = VEC[k][27:20];
      #1;
      chk($sformatf("R6 vec%0d dir a_oe", k), {7'd0, a_oe_d}, {7'd0, VEC[k][19]});
      chk($sformatf("R6 vec%0d dir b_oe", k), {7'd0, b_oe_d}, {7'd0, VEC[k][18]});
      chk($sformatf("R7 vec%0d split a_oe", k), {7'd0, a_oe_s}, {7'd0, VEC[k][17]});
      chk($sformatf("R7 vec%0d split b_oe", k), {7'd0, b_oe_s}, {7'd0, VEC[k][16]});
      // R9: outputs carry the selected word even where oe is low
      chk($sformatf("R5 R9 vec%0d a_out", k), a_out_d, VEC[k][15:8]);
      chk($sformatf("R4 R9 vec%0d b_out", k), b_out_d, VEC[k][7:0]);
      chk($sformatf("R5 vec%0d a_out split", k), a_out_s, VEC[k][15:8]);
      chk($sformatf("R4 vec%0d b_out split", k), b_out_s, VEC[k][7:0]);
    end

    // hold: new bus data without strobes leaves the stores alone
    @(negedge clk) sel_a2b = 1; sel_b2a = 1; a_in = 8'h77; b_in = 8'h88;
    cap_a = 0; cap_b = 0;
    @(negedge clk) #1;
    chk("R2 hold without strobe", b_out_d, 8'h3C);
    chk("R3 hold without strobe", a_out_d, 8'hA5);

    // capture while isolated and with live selects
    @(negedge clk) ctrl0 = 1; ctrl1 = 1; sel_a2b = 0; sel_b2a = 0;
    a_in = 8'h96; b_in = 8'h69; cap_a = 1; cap_b = 1;
    @(negedge clk) cap_a = 0; cap_b = 0; sel_a2b = 1; sel_b2a = 1;
    a_in = 8'h00; b_in = 8'h00;
    #1;
    chk("R2 capture ignores oe/select", b_out_d, 8'h96);
    chk("R3 capture ignores oe/select", a_out_d, 8'h69);

    // one word into both registers: drive B with live A, loop back
    @(negedge clk) ctrl0 = 0; ctrl1 = 1; sel_a2b = 0; sel_b2a = 1; a_in = 8'h6B;
    #1;
    b_in = b_out_d;
    chk("R8 B side driven", {7'd0, b_oe_d}, 8'h01);
    cap_a = 1; cap_b = 1;
    @(negedge clk) cap_a = 0; cap_b = 0; sel_a2b = 1; a_in = 8'h00; b_in = 8'h00;
    #1;
    chk("R8 B store got driven word", a_out_d, 8'h6B);
    chk("R8 A store got same word", b_out_d, 8'h6B);

    // reset again mid-run
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    #1;
    chk("R1 re-reset A store", b_out_d, 8'h00);
    chk("R1 re-reset B store", a_out_d, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule